// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel characters. It runs from the system clock and a sample-enable pulse, `tick_i`, that arrives sixteen times per bit. The line input first passes through a two-flop synchroniser. The block then finds and checks the start bit, samples each following bit at its centre, and assembles 5 to 8 data bits. An optional parity bit and one stop bit follow the data bits.

Each finished character comes out as a one-cycle strobe. The data byte and three status flags (parity error, framing error, break) are updated in that same cycle and hold their values until the next character. Three configuration inputs set the character length, parity on or off, and the parity type. They should be held stable while a character is being received. A low enable input stops reception at once, and the character in progress is dropped.

Two recovery rules decide where the next character starts after a bad stop bit. A framing error on a character with at least one high bit re-checks the line half a bit later and may start a new character there. A line held low for a whole frame produces exactly one break character, and the receiver then waits for the line to go high again.

Top module: `oversampled_rx`

## Requirements
- R1: Start detection uses the synchronised line. A falling edge seen between two consecutive ticks starts a check, and the line is sampled again on the 8th tick after that. If the line is high at that sample, no character is produced and the receiver goes back to looking for a falling edge.
- R2: After the start bit is accepted, each later bit is sampled on every 16th tick, at the bit's centre. Data bits arrive least significant bit first.
- R3: `char_len_i` sets the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7, 3 gives 8. Bits of `data_o` above the character length are zero.
- R4: When `par_en_i` is 1, one parity bit follows the last data bit. `par_odd_i` = 1 selects odd parity and 0 selects even parity. `par_err_o` is 1 when the total count of ones in the data and parity bits does not match the selected type. When `par_en_i` is 0, `par_err_o` is 0.
- R5: Only one stop bit is sampled. A high stop bit gives `frm_err_o` = 0. A low stop bit on a character that has at least one high data or parity bit gives `frm_err_o` = 1.
- R6: After a high stop bit, the receiver looks for the next falling edge at once, so two frames with no idle time between them are both received.
- R7: After a framing error, the line is sampled 8 ticks after the stop sample. If it is low, that point is treated as a new start edge and its start check follows 8 ticks later. If it is high, the receiver goes idle.
- R8: If all data bits, the parity bit (when enabled) and the stop bit are low, exactly one character is produced with `data_o` = 0, `brk_o` = 1, `frm_err_o` = 0 and `par_err_o` = 0.
- R9: After a break, start detection resumes only after the synchronised line has been high on two consecutive clock edges. No further character is produced while the line stays low.
- R10: `valid_o` is high for one clock cycle, in the cycle after the stop sample. `data_o` and all three flags change only in that cycle and hold their values otherwise.
- R11: While `en_i` is 0, the character in progress is discarded and no character is produced. After `en_i` returns to 1, reception starts again at the next falling edge.
- R12: After reset, `valid_o`, `data_o` and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample enable, 16 pulses per bit |
| en_i | input | 1 | Receiver enable; low aborts the character in progress |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| char_len_i | input | 2 | Data bits minus 5 |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| valid_o | output | 1 | One-cycle character strobe |
| data_o | output | 8 | Received character, unused upper bits zero |
| par_err_o | output | 1 | Parity error for the character |
| frm_err_o | output | 1 | Framing error for the character |
| brk_o | output | 1 | Character is a break |

## Verification
Two events can land close together. The character strobe of one frame and the start-edge detection of the next frame can fall in the same cycle when frames are sent with no idle gap. Equally, the framing-error strobe is followed within half a bit by the re-start decision. The bench sends a frame with a low stop bit and starts the next frame directly after it, so that its start bit continues the low level. It also sends a pair of frames with no gap between them. In both cases it checks that both characters arrive with the correct bytes and flags. A mistimed restart shows up as a lost or shifted second byte.

// File: rtl/rx_pkg.sv
package rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_FE_WAIT,
    ST_BRK_WAIT
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/rx_tick_timer.sv
module rx_tick_timer #(
  parameter int unsigned OSR = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic half_o,
  output logic full_o
);
  localparam int unsigned CW = $clog2(OSR);
  localparam logic [CW-1:0] HALF_LAST = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] FULL_LAST = CW'(OSR - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  // nth tick after a clear
  assign half_o = tick_i && (cnt_q == HALF_LAST);
  assign full_o = tick_i && (cnt_q == FULL_LAST);
endmodule

// File: rtl/rx_assembler.sv
module rx_assembler #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      wr_i,
  input  logic [$clog2(DATA_W)-1:0] idx_i,
  input  logic                      bit_i,
  output logic [DATA_W-1:0]         data_o,
  output logic                      par_o
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sh_q <= '0;
    else if (clr_i) sh_q <= '0;
    else if (wr_i)  sh_q[idx_i] <= bit_i;
  end

  assign data_o = sh_q;
  assign par_o  = ^sh_q;
endmodule

// File: rtl/oversampled_rx.sv
module oversampled_rx #(
  parameter int unsigned OSR         = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned LEN_W       = 2,
  parameter int unsigned MIN_LEN     = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              rxd_i,
  input  logic [LEN_W-1:0]  char_len_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              brk_o
);
  import rx_pkg::*;

  localparam int unsigned IDX_W = $clog2(DATA_W);

  rx_state_e         state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  last_idx;
  logic              line;
  logic              ref_q;
  logic              nz_q;
  logic              parbit_q;
  logic              hi_seen_q;
  logic              tmr_clr, tmr_half, tmr_full;
  logic              asm_clr, asm_wr, asm_par;
  logic [DATA_W-1:0] asm_data;
  logic              valid_q, pe_q, fe_q, brk_q;
  logic [DATA_W-1:0] data_q;

  rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (line)
  );

  rx_tick_timer #(.OSR(OSR)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tmr_clr),
    .tick_i(tick_i),
    .half_o(tmr_half),
    .full_o(tmr_full)
  );

  rx_assembler #(.DATA_W(DATA_W)) u_asm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (asm_clr),
    .wr_i  (asm_wr),
    .idx_i (idx_q),
    .bit_i (line),
    .data_o(asm_data),
    .par_o (asm_par)
  );

  assign last_idx = IDX_W'(MIN_LEN - 1) + IDX_W'(char_len_i);

  always_comb begin
    tmr_clr = 1'b0;
    asm_clr = (state_q == ST_START);
    asm_wr  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_BRK_WAIT:  tmr_clr = 1'b1;
      ST_START, ST_FE_WAIT:  tmr_clr = tmr_half;
      ST_DATA: begin
        tmr_clr = tmr_full;
        asm_wr  = tmr_full && en_i;
      end
      ST_PAR, ST_STOP:       tmr_clr = tmr_full;
      default:               tmr_clr = 1'b1;
    endcase
    if (!en_i) tmr_clr = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      ref_q     <= 1'b1;
      nz_q      <= 1'b0;
      parbit_q  <= 1'b0;
      hi_seen_q <= 1'b0;
      valid_q   <= 1'b0;
      data_q    <= '0;
      pe_q      <= 1'b0;
      fe_q      <= 1'b0;
      brk_q     <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
        ref_q   <= line;
      end else begin
        unique case (state_q)
          ST_IDLE: if (tick_i) begin
            ref_q <= line;
            if (ref_q && !line) state_q <= ST_START;
          end
          ST_START: if (tmr_half) begin
            if (line) begin
              state_q <= ST_IDLE;
              ref_q   <= 1'b1;
            end else begin
              state_q <= ST_DATA;
              idx_q   <= '0;
              nz_q    <= 1'b0;
            end
          end
          ST_DATA: if (tmr_full) begin
            nz_q <= nz_q | line;
            if (idx_q == last_idx) state_q <= par_en_i ? ST_PAR : ST_STOP;
            else                   idx_q   <= idx_q + 1'b1;
          end
          ST_PAR: if (tmr_full) begin
            parbit_q <= line;
            nz_q     <= nz_q | line;
            state_q  <= ST_STOP;
          end
          ST_STOP: if (tmr_full) begin
            valid_q <= 1'b1;
            if (line || nz_q) begin
              data_q  <= asm_data;
              pe_q    <= par_en_i && (asm_par ^ parbit_q ^ par_odd_i);
              fe_q    <= !line;
              brk_q   <= 1'b0;
              state_q <= line ? ST_IDLE : ST_FE_WAIT;
              ref_q   <= 1'b1;
            end else begin
              // whole frame low: one break character
              data_q    <= '0;
              pe_q      <= 1'b0;
              fe_q      <= 1'b0;
              brk_q     <= 1'b1;
              hi_seen_q <= 1'b0;
              state_q   <= ST_BRK_WAIT;
            end
          end
          ST_FE_WAIT: if (tmr_half) begin
            if (!line) state_q <= ST_START;
            else begin
              state_q <= ST_IDLE;
              ref_q   <= 1'b1;
            end
          end
          ST_BRK_WAIT: begin
            hi_seen_q <= line;
            if (line && hi_seen_q) begin
              state_q <= ST_IDLE;
              ref_q   <= 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign valid_o   = valid_q;
  assign data_o    = data_q;
  assign par_err_o = pe_q;
  assign frm_err_o = fe_q;
  assign brk_o     = brk_q;
endmodule

// File: rtl/oversampled_rx_chk.sv
module oversampled_rx_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] data_o,
  input logic              par_err_o,
  input logic              frm_err_o,
  input logic              brk_o
);
  assert_single_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_hold_outputs_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(data_o) && $stable(brk_o) && $stable(frm_err_o) && $stable(par_err_o)));

  assert_break_char_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && brk_o) |-> (data_o == '0 && !frm_err_o && !par_err_o));

  assert_disable_drops_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !valid_o);
endmodule

bind oversampled_rx oversampled_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .valid_o  (valid_o),
  .data_o   (data_o),
  .par_err_o(par_err_o),
  .frm_err_o(frm_err_o),
  .brk_o    (brk_o)
);

// File: tb/oversampled_rx_tb_top.sv
module oversampled_rx_tb_top;
  localparam int BIT_CLKS = 64;  // 16 ticks x 4 clocks
  localparam int NVEC     = 8;
  // [1:0] len [2] par_en [3] odd [4] stop [5] flip parity
  // [15:8] sent [23:16] expected data [24] exp pe [25] exp fe
  localparam logic [31:0] VEC [NVEC] = '{
    32'h00A5A513, 32'h001FFF10, 32'h00555516, 32'h013F3F3D,
    32'h0001011F, 32'h02818103, 32'h00000014, 32'h01FEFE37
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick;
  logic en = 1'b1;
  logic rxd = 1'b1;
  logic [1:0] len = 2'd3;
  logic pen = 1'b0;
  logic odd = 1'b0;
  logic valid, pe, fe, brk;
  logic [7:0] data;
  logic [1:0] tcnt;

  int n_chk = 0;
  int n_fail = 0;
  int n_valid = 0;
  logic [7:0] cap_data [32];
  logic [2:0] cap_flag [32];  // {brk, fe, pe}

  always #10 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tcnt <= '0;
    else        tcnt <= tcnt + 1'b1;
  end
  assign tick = (tcnt == 2'd3);

  oversampled_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .en_i(en), .rxd_i(rxd),
    .char_len_i(len), .par_en_i(pen), .par_odd_i(odd),
    .valid_o(valid), .data_o(data), .par_err_o(pe), .frm_err_o(fe), .brk_o(brk)
  );

  always @(negedge clk) begin
    if (valid) begin
      cap_data[n_valid[4:0]] <= data;
      cap_flag[n_valid[4:0]] <= {brk, fe, pe};
      n_valid <= n_valid + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [1:0] l, input logic pe_on, input logic od,
                            input logic [7:0] d, input logic stop_lvl, input logic flip,
                            input int stop_clks);
    logic [7:0] mask;
    mask = 8'((16'd1 << (5 + l)) - 1);
    rxd = 1'b0;
    wait_clks(BIT_CLKS);
    for (int i = 0; i < 5 + int'(l); i++) begin
      rxd = d[i];
      wait_clks(BIT_CLKS);
    end
    if (pe_on) begin
      rxd = (^(d & mask)) ^ od ^ flip;
      wait_clks(BIT_CLKS);
    end
    rxd = stop_lvl;
    wait_clks(stop_clks);
    rxd = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n0;
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(3);
    // R12 reset state
    check(valid == 1'b0, "R12 valid", 32'(valid), 0);
    check({data, pe, fe, brk} == '0, "R12 outputs", 32'({data, pe, fe, brk}), 0);
    wait_clks(100);

    // table: R2 R3 R4 R5
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] e;
      e = VEC[v];
      len = e[1:0]; pen = e[2]; odd = e[3];
      n0 = n_valid;
      send_frame(e[1:0], e[2], e[3], e[15:8], e[4], e[5], e[4] ? BIT_CLKS : 48);
      wait_clks(2 * BIT_CLKS);
      check(n_valid == n0 + 1, "R2 char count", 32'(n_valid - n0), 1);
      check(cap_data[n0[4:0]] == e[23:16], "R2 R3 data", 32'(cap_data[n0[4:0]]), 32'(e[23:16]));
      check(cap_flag[n0[4:0]][0] == e[24], "R4 parity flag", 32'(cap_flag[n0[4:0]][0]), 32'(e[24]));
      check(cap_flag[n0[4:0]][1] == e[25], "R5 framing flag", 32'(cap_flag[n0[4:0]][1]), 32'(e[25]));
    end
    len = 2'd3; pen = 1'b0; odd = 1'b0;

    // R1 false start: 2-tick low glitch is rejected
    n0 = n_valid;
    rxd = 1'b0; wait_clks(8); rxd = 1'b1;
    wait_clks(4 * BIT_CLKS);
    check(n_valid == n0, "R1 glitch rejected", 32'(n_valid - n0), 0);
    send_frame(2'd3, 1'b0, 1'b0, 8'h3C, 1'b1, 1'b0, BIT_CLKS);
    wait_clks(2 * BIT_CLKS);
    check(n_valid == n0 + 1 && cap_data[n0[4:0]] == 8'h3C, "R1 resume", 32'(cap_data[n0[4:0]]), 32'h3C);

    // R6 back-to-back frames
    n0 = n_valid;
    send_frame(2'd3, 1'b0, 1'b0, 8'h12, 1'b1, 1'b0, BIT_CLKS);
    send_frame(2'd3, 1'b0, 1'b0, 8'hED, 1'b1, 1'b0, BIT_CLKS);
    wait_clks(2 * BIT_CLKS);
    check(n_valid == n0 + 2, "R6 count", 32'(n_valid - n0), 2);
    check(cap_data[n0[4:0]] == 8'h12, "R6 first", 32'(cap_data[n0[4:0]]), 32'h12);
    check(cap_data[5'(n0 + 1)] == 8'hED, "R6 second", 32'(cap_data[5'(n0 + 1)]), 32'hED);

    // R7 framing error followed directly by a start bit
    n0 = n_valid;
    send_frame(2'd3, 1'b0, 1'b0, 8'h0F, 1'b0, 1'b0, BIT_CLKS);
    send_frame(2'd3, 1'b0, 1'b0, 8'h3C, 1'b1, 1'b0, BIT_CLKS);
    wait_clks(2 * BIT_CLKS);
    check(n_valid == n0 + 2, "R7 count", 32'(n_valid - n0), 2);
    check(cap_data[n0[4:0]] == 8'h0F && cap_flag[n0[4:0]] == 3'b010, "R7 first fe",
          32'({cap_data[n0[4:0]], cap_flag[n0[4:0]]}), 32'({8'h0F, 3'b010}));
    check(cap_data[5'(n0 + 1)] == 8'h3C && cap_flag[5'(n0 + 1)] == 3'b000, "R7 restart",
          32'({cap_data[5'(n0 + 1)], cap_flag[5'(n0 + 1)]}), 32'({8'h3C, 3'b000}));

    // R8 break, R9 recovery
    n0 = n_valid;
    rxd = 1'b0; wait_clks(12 * BIT_CLKS); rxd = 1'b1;
    wait_clks(2 * BIT_CLKS);
    check(n_valid == n0 + 1, "R8 single break char", 32'(n_valid - n0), 1);
    check(cap_data[n0[4:0]] == 8'h00 && cap_flag[n0[4:0]] == 3'b100, "R8 break flags",
          32'({cap_data[n0[4:0]], cap_flag[n0[4:0]]}), 32'({8'h00, 3'b100}));
    send_frame(2'd3, 1'b0, 1'b0, 8'h5A, 1'b1, 1'b0, BIT_CLKS);
    wait_clks(2 * BIT_CLKS);
    check(n_valid == n0 + 2 && cap_data[5'(n0 + 1)] == 8'h5A, "R9 after break",
          32'(cap_data[5'(n0 + 1)]), 32'h5A);

    // R11 disable mid-character
    n0 = n_valid;
    fork
      send_frame(2'd3, 1'b0, 1'b0, 8'hA5, 1'b1, 1'b0, BIT_CLKS);
      begin wait_clks(3 * BIT_CLKS); en = 1'b0; end
    join
    wait_clks(BIT_CLKS);
    en = 1'b1;
    wait_clks(BIT_CLKS);
    check(n_valid == n0, "R11 aborted", 32'(n_valid - n0), 0);
    send_frame(2'd3, 1'b0, 1'b0, 8'h66, 1'b1, 1'b0, BIT_CLKS);
    wait_clks(2 * BIT_CLKS);
    check(n_valid == n0 + 1 && cap_data[n0[4:0]] == 8'h66, "R11 resume", 32'(cap_data[n0[4:0]]), 32'h66);

    // R10 outputs held between strobes
    check(data == 8'h66 && valid == 1'b0, "R10 hold", 32'({valid, data}), 32'h66);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule